// File: doc/BRIEF.md
# Clock-Enable Suspend and Low-Power Controller

This block governs the clock-enable path of a two-bank synchronous graphics memory. On every rising clock edge it samples the external clock-enable pin. Whether that pin is high or low, the block turns it into a registered internal clock-enable. It also drives a freeze flag, which holds the burst address and the output registers while the internal clock is stopped.

When clock enable is sampled low, the outcome depends on the banks. If any bank still has a row open, the result is a plain clock suspend, one cycle at a time. If every bank is idle, the block enters a low-power state instead: power-down by default, or self-refresh when a refresh request is present. While in low power the input buffers are reported as disabled, and they come back as soon as clock enable rises, with no clock edge needed. The internal clock only restarts after clock enable has been seen high for one further full cycle.

Top module: `ckeSuspendCtl`

## Requirements
- R1: While reset is asserted and directly after it, the block is running: clkEnInt=1, freeze=0, bufEn=1 and modeState=4'b0001.
- R2: modeState is one-hot with bit 0 = running, bit 1 = suspended, bit 2 = power-down and bit 3 = self-refresh. In every state, clkEnInt is high only in the running state and freeze is its complement.
- R3: When running, cke sampled low while at least one bankIdle bit is 0 makes the block suspended after that edge. Before that edge, clkEnInt stays 1.
- R4: While suspended, each edge that samples cke low keeps the block suspended. The first edge that samples cke high returns it to running.
- R5: When running, cke sampled low with all bankIdle bits 1 and selfRefReq=0 enters power-down.
- R6: When running, cke sampled low with all bankIdle bits 1 and selfRefReq=1 enters self-refresh.
- R7: In power-down or self-refresh, bufEn equals cke combinationally, with no clock edge involved. In running and suspended states bufEn is 1.
- R8: From power-down or self-refresh, the block returns to running only after cke has been sampled high on EXIT_CYCLES+1 consecutive edges (two with the default). clkEnInt is 1 from the last of those edges onward.
- R9: A cke low sample during the exit window cancels it, and the full count of high samples is needed again.
- R10: While suspended, bankIdle and selfRefReq have no effect: the block never moves from suspended into a low-power state.
- R11: While running with cke high, bankIdle and selfRefReq have no effect: the block stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | External clock-enable pin |
| selfRefReq | input | 1 | Picks self-refresh instead of power-down on low-power entry |
| bankIdle | input | NUM_BANKS | One bit per bank, 1 when the bank has no open row |
| clkEnInt | output | 1 | Internal clock enable |
| freeze | output | 1 | Hold burst address and output registers |
| modeState | output | 4 | One-hot state: run, suspend, power-down, self-refresh |
| bufEn | output | 1 | Input buffers, including the clock buffer, enabled |

## Verification
The clocked properties assume that cke, bankIdle and selfRefReq are settled at each rising edge. They also assume that cke changes only between edges, including its asynchronous rise during low power. The bench changes inputs only on falling edges, so both assumptions hold. For the asynchronous wake-up, it probes bufEn within the same half cycle, before any rising edge can sample the new cke level.

// File: rtl/ckeCtlPkg.sv
package ckeCtlPkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_SUSP = 2'd1,
    MODE_PDN  = 2'd2,
    MODE_SREF = 2'd3
  } mode_e;

  typedef struct packed {
    logic runSel;
    logic suspSel;
    logic pdnSel;
    logic srefSel;
    logic armInc;
    logic armClr;
  } ckeStrobes_t;

endpackage

// File: rtl/ckeCtlFsm.sv
module ckeCtlFsm
  import ckeCtlPkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 selfRefReq,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic                 exitDone,
  output ckeStrobes_t          strobes
);

  mode_e state, nextState;
  logic allIdle;

  assign allIdle = &bankIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState      = state;
    strobes.armInc = 1'b0;
    strobes.armClr = 1'b0;
    case (state)
      MODE_RUN: begin
        if (!cke) begin
          if (allIdle) nextState = selfRefReq ? MODE_SREF : MODE_PDN;
          else         nextState = MODE_SUSP;
        end
      end
      MODE_SUSP: begin
        if (cke) nextState = MODE_RUN;
      end
      MODE_PDN, MODE_SREF: begin
        if (!cke) begin
          strobes.armClr = 1'b1;
        end else if (exitDone) begin
          nextState      = MODE_RUN;
          strobes.armClr = 1'b1;
        end else begin
          strobes.armInc = 1'b1;
        end
      end
      default: nextState = MODE_RUN;
    endcase
  end

  assign strobes.runSel  = (state == MODE_RUN);
  assign strobes.suspSel = (state == MODE_SUSP);
  assign strobes.pdnSel  = (state == MODE_PDN);
  assign strobes.srefSel = (state == MODE_SREF);

endmodule

// File: rtl/ckeCtlPath.sv
module ckeCtlPath
  import ckeCtlPkg::*;
#(
  parameter int EXIT_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cke,
  input  ckeStrobes_t strobes,
  output logic        exitDone,
  output logic        clkEnInt,
  output logic        freeze,
  output logic [3:0]  modeState,
  output logic        bufEn
);

  localparam int CW = (EXIT_CYCLES < 1) ? 1 : $clog2(EXIT_CYCLES + 1);

  logic [CW-1:0] armCnt;
  logic          lowPower;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               armCnt <= '0;
    else if (strobes.armClr) armCnt <= '0;
    else if (strobes.armInc) armCnt <= armCnt + 1'b1;
  end

  assign exitDone  = (armCnt >= CW'(EXIT_CYCLES));
  assign lowPower  = strobes.pdnSel | strobes.srefSel;
  assign clkEnInt  = strobes.runSel;
  assign freeze    = ~strobes.runSel;
  assign modeState = {strobes.srefSel, strobes.pdnSel, strobes.suspSel, strobes.runSel};
  // Wake-up path: no register between the pin and the buffer flag.
  assign bufEn     = ~lowPower | cke;

endmodule

// File: rtl/ckeSuspendCtl.sv
module ckeSuspendCtl
  import ckeCtlPkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int EXIT_CYCLES = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 selfRefReq,
  input  logic [NUM_BANKS-1:0] bankIdle,
  output logic                 clkEnInt,
  output logic                 freeze,
  output logic [3:0]           modeState,
  output logic                 bufEn
);

  ckeStrobes_t strobes;
  logic        exitDone;

  ckeCtlFsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk(clk), .rstN(rstN), .cke(cke), .selfRefReq(selfRefReq),
    .bankIdle(bankIdle), .exitDone(exitDone), .strobes(strobes)
  );

  ckeCtlPath #(.EXIT_CYCLES(EXIT_CYCLES)) u_path (
    .clk(clk), .rstN(rstN), .cke(cke), .strobes(strobes),
    .exitDone(exitDone), .clkEnInt(clkEnInt), .freeze(freeze),
    .modeState(modeState), .bufEn(bufEn)
  );

endmodule

// File: rtl/ckeSuspendCtlChk.sv
module ckeSuspendCtlChk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cke,
  input logic                 selfRefReq,
  input logic [NUM_BANKS-1:0] bankIdle,
  input logic                 clkEnInt,
  input logic                 freeze,
  input logic [3:0]           modeState,
  input logic                 bufEn
);

  logic lowPower;
  assign lowPower = modeState[2] | modeState[3];

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(modeState) && (clkEnInt == modeState[0]) && (freeze != clkEnInt));

  p_suspend_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeState[0] && !cke && !(&bankIdle)) |=> modeState[1]);

  p_suspend_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeState[1] && !cke) |=> modeState[1]);

  p_suspend_wake_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeState[1] && cke) |=> modeState[0]);

  p_pdn_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeState[0] && !cke && (&bankIdle) && !selfRefReq) |=> modeState[2]);

  p_sref_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeState[0] && !cke && (&bankIdle) && selfRefReq) |=> modeState[3]);

  p_buf_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufEn == (!lowPower || cke));

  p_no_early_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && !cke) |=> !clkEnInt);

  p_run_stays_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeState[0] && cke) |=> modeState[0]);

endmodule

bind ckeSuspendCtl ckeSuspendCtlChk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .selfRefReq(selfRefReq),
  .bankIdle(bankIdle), .clkEnInt(clkEnInt), .freeze(freeze),
  .modeState(modeState), .bufEn(bufEn)
);

// File: tb/ckeSuspendCtl_test.sv
module ckeSuspendCtl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] M_RUN = 4'b0001, M_SUSP = 4'b0010,
                         M_PDN = 4'b0100, M_SREF = 4'b1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1;
  logic selfRefReq = 1'b0;
  logic [1:0] bankIdle = 2'b00;
  logic clkEnInt, freeze, bufEn;
  logic [3:0] modeState;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] mode;
    logic       ckeVal;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  ckeSuspendCtl uut (
    .clk(clk), .rstN(rstN), .cke(cke), .selfRefReq(selfRefReq),
    .bankIdle(bankIdle), .clkEnInt(clkEnInt), .freeze(freeze),
    .modeState(modeState), .bufEn(bufEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare outputs just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      logic lp, expBuf;
      it = expQ.pop_front();
      lp = it.mode[2] | it.mode[3];
      expBuf = !lp || it.ckeVal;
      chk({it.tag, " mode"}, {4'b0, modeState}, {4'b0, it.mode});
      chk({it.tag, " clken/freeze R2"}, {6'b0, clkEnInt, freeze},
          {6'b0, (it.mode == M_RUN), (it.mode != M_RUN)});
      chk({it.tag, " bufEn R7"}, {7'b0, bufEn}, {7'b0, expBuf});
    end
  end

  // Driver: apply inputs on the falling edge, push the expectation for after the next rising edge.
  task automatic step(input logic c, input logic [1:0] idle, input logic sr,
                      input logic [3:0] expMode, input string tag, input int mid);
    expItem_t it;
    @(negedge clk);
    cke = c; bankIdle = idle; selfRefReq = sr;
    if (mid == 1) begin
      #1 chk("R3 clkEnInt held before edge", {7'b0, clkEnInt}, 8'h01);
    end
    if (mid == 2) begin
      #1 chk("R7 bufEn async wake", {7'b0, bufEn}, 8'h01);
    end
    it.mode = expMode; it.ckeVal = c; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk("R1 reset mode", {4'b0, modeState}, {4'b0, M_RUN});
    chk("R1 reset clken/freeze/buf", {5'b0, clkEnInt, freeze, bufEn}, 8'h05);
    @(negedge clk);
    rstN = 1'b1;

    step(1, 2'b00, 0, M_RUN,  "R1 run after reset", 0);
    step(1, 2'b11, 1, M_RUN,  "R11 idle ignored", 0);
    step(0, 2'b01, 0, M_SUSP, "R3 suspend entry", 1);
    step(0, 2'b11, 1, M_SUSP, "R10 idle in suspend", 0);
    step(0, 2'b11, 0, M_SUSP, "R4 suspend hold", 0);
    step(1, 2'b11, 0, M_RUN,  "R4 suspend wake", 0);
    step(0, 2'b11, 0, M_PDN,  "R5 power-down entry", 0);
    step(0, 2'b11, 0, M_PDN,  "R5 power-down hold", 0);
    step(1, 2'b11, 0, M_PDN,  "R8 exit first sample", 2);
    step(0, 2'b11, 0, M_PDN,  "R9 exit cancelled", 0);
    step(1, 2'b11, 0, M_PDN,  "R9 exit restarted", 0);
    step(1, 2'b11, 0, M_RUN,  "R8 exit complete", 0);
    step(0, 2'b11, 1, M_SREF, "R6 self-refresh entry", 0);
    step(0, 2'b00, 0, M_SREF, "R6 self-refresh hold", 0);
    step(1, 2'b00, 0, M_SREF, "R8 sref exit first", 2);
    step(1, 2'b00, 0, M_RUN,  "R8 sref exit done", 0);
    step(0, 2'b10, 1, M_SUSP, "R3 suspend second bank busy", 1);
    step(1, 2'b10, 1, M_RUN,  "R4 resume", 0);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
  end

  initial begin : watchdog
    fork
      wait (finished);
      begin
        #(CLK_PERIOD * 5000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule